// File: doc/BRIEF.md
# Synchronous Buck Gate Sequencer

This block sits between the digital outputs of a hysteretic converter's comparators and the gate drivers of one synchronous buck phase. Each clock cycle it decides whether the high-side switch, the low-side switch or neither should conduct. It then turns that decision into two registered drive requests. Those requests never overlap, and a programmable number of idle cycles separates one switch turning off from either switch turning on.

The voltage comparator sets the normal choice: a high input asks for the high-side switch and a low input asks for the low-side switch. Two current-limit flags override that choice. When the sensed current reaches the upper limit, the high-side pulse is cut. The phase then stays on the low side until the current has fallen below the lower limit. In powersave mode a zero-crossing flag ends low-side conduction, so no reverse inductor current can flow. The phase then stays idle until the next high-side request. A force-low-side input from the fault logic pins the phase to the low side. A run enable turns the whole stage off.

The four comparator flags are asynchronous. Each passes through a synchronizer chain before any decision uses it. The run enable, force and powersave inputs are synchronous to the clock and are used directly.

Top module: `buck_gate_seq`

## Requirements
- R1: While reset is asserted, both `hs_gate_o` and `ls_gate_o` are 0.
- R2: When `run_en_i` is 0 at a clock edge, both outputs are 0 after that edge. This takes precedence over every other input.
- R3: With run enabled, no force, no current limit and no powersave, a 1 on `vcmp_i` leads to `hs_gate_o`=1 and a 0 leads to `ls_gate_o`=1.
- R4: `hs_gate_o` and `ls_gate_o` are never 1 in the same cycle.
- R5: After either output falls, both outputs stay 0 for exactly `DEAD_CYCLES` clock cycles before either output rises. The counter starts at 0 out of reset, so the first switch-on after reset waits no idle cycles.
- R6: Once the synchronized `ilim_hi_i` is 1, `hs_gate_o` goes to 0 at the next edge. It stays 0 while the synchronized `ilim_lo_i` remains 1, and the phase uses the low side during that time.
- R7: After a current-limit cut, the low-side interval ends when the synchronized `ilim_lo_i` falls to 0. The high side may then be requested again by `vcmp_i`.
- R8: With `pwrsave_i`=1 and no high-side demand, a synchronized `izero_i`=1 drops `ls_gate_o` at the next edge. The phase stays idle even after `izero_i` returns to 0. It leaves that idle state when a high-side demand arrives or `pwrsave_i` goes to 0.
- R9: With run enabled, `force_lo_i`=1 turns `hs_gate_o` off at the next edge. After the dead time it holds `ls_gate_o`=1, whatever the comparator and current-limit inputs do.
- R10: Each of `vcmp_i`, `ilim_hi_i`, `ilim_lo_i` and `izero_i` passes through `SYNC_STAGES` flops (default 2). A change is therefore seen by the decision logic only after that many edges, and an output reacts at edge `SYNC_STAGES`+1 at the earliest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en_i | input | 1 | Run enable; 0 turns both switches off |
| force_lo_i | input | 1 | Fault override holding the low side on |
| pwrsave_i | input | 1 | Enables zero-crossing cut-off of the low side |
| vcmp_i | input | 1 | Hysteretic voltage comparator, 1 requests high side |
| ilim_hi_i | input | 1 | Sensed current at or above the upper limit |
| ilim_lo_i | input | 1 | Sensed current at or above the lower limit |
| izero_i | input | 1 | Inductor current at or below zero |
| hs_gate_o | output | 1 | High-side gate drive request |
| ls_gate_o | output | 1 | Low-side gate drive request |

## Verification
The bound checker watches several properties on every cycle: that the two requests never overlap, and that the idle gap before each rising request is at least the dead time. It also checks the one-edge reactions to run enable, force, the upper current limit and the powersave zero crossing. The bench's scenarios are needed for the rest. These are the current-limit hold lasting until the lower flag drops, the powersave latch outliving the zero-crossing flag, the exact synchronizer latency, and the cycle on which each switch comes back on. A cycle-accurate bench model, fed with seeded random stimulus, then cross-checks both requests on every cycle.

// File: rtl/bgs_pkg.sv
package bgs_pkg;

   typedef enum logic [1:0] {
      SIDE_OFF = 2'd0,
      SIDE_HI  = 2'd1,
      SIDE_LO  = 2'd2
   } side_e;

   localparam int unsigned FLAG_VCMP   = 0;
   localparam int unsigned FLAG_LIMHI  = 1;
   localparam int unsigned FLAG_LIMLO  = 2;
   localparam int unsigned FLAG_ZERO   = 3;
   localparam int unsigned FLAG_COUNT  = 4;

endpackage

// File: rtl/bgs_sync.sv
module bgs_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("bgs_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("bgs_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= d_i;
         for (int s = 1; s < int'(STAGES); s++) begin
            chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/bgs_decide.sv
module bgs_decide
   import bgs_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  run_en,
   input  logic  force_lo,
   input  logic  pwrsave,
   input  logic  vcmp_s,
   input  logic  lim_hi_s,
   input  logic  lim_lo_s,
   input  logic  zero_s,
   output side_e want_o
);

   logic hold_q, hold_now;
   logic idle_q, idle_now;
   logic hs_req;

   always_comb begin
      // current-limit hysteresis: set at the upper flag, kept while the lower flag holds
      hold_now = lim_hi_s | (hold_q & lim_lo_s);
      hs_req   = vcmp_s & ~hold_now;
      // powersave idle: set by a zero crossing, kept until a high-side demand
      idle_now = pwrsave & ~hs_req & (zero_s | idle_q);

      if (!run_en) begin
         want_o = SIDE_OFF;
      end else if (force_lo) begin
         want_o = SIDE_LO;
      end else if (hs_req) begin
         want_o = SIDE_HI;
      end else if (idle_now) begin
         want_o = SIDE_OFF;
      end else begin
         want_o = SIDE_LO;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
         idle_q <= 1'b0;
      end else begin
         hold_q <= run_en & hold_now;
         idle_q <= run_en & idle_now;
      end
   end

endmodule

// File: rtl/bgs_deadtime.sv
module bgs_deadtime
   import bgs_pkg::*;
#(
   parameter int unsigned DEAD_CYCLES = 4
) (
   input  logic  clk,
   input  logic  rst_n,
   input  side_e want_i,
   output logic  hs_o,
   output logic  ls_o
);

   localparam int unsigned CNT_W = (DEAD_CYCLES < 2) ? 1 : $clog2(DEAD_CYCLES);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(DEAD_CYCLES - 1);

   side_e            drv_q;
   logic [CNT_W-1:0] gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drv_q <= SIDE_OFF;
         gap_q <= '0;
      end else if (drv_q != SIDE_OFF) begin
         if (want_i != drv_q) begin
            drv_q <= SIDE_OFF;
            gap_q <= LOAD;
         end
      end else if (gap_q != '0) begin
         gap_q <= gap_q - 1'b1;
      end else if (want_i != SIDE_OFF) begin
         drv_q <= want_i;
      end
   end

   assign hs_o = (drv_q == SIDE_HI);
   assign ls_o = (drv_q == SIDE_LO);

endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq
   import bgs_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DEAD_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_en_i,
   input  logic force_lo_i,
   input  logic pwrsave_i,
   input  logic vcmp_i,
   input  logic ilim_hi_i,
   input  logic ilim_lo_i,
   input  logic izero_i,
   output logic hs_gate_o,
   output logic ls_gate_o
);

   generate
      if (DEAD_CYCLES < 1) begin : g_bad_dead
         $error("buck_gate_seq: DEAD_CYCLES must be at least 1");
      end
   endgenerate

   logic [FLAG_COUNT-1:0] flags_raw, flags_s;
   logic  vcmp_s, lim_hi_s, lim_lo_s, zero_s;
   side_e want;

   always_comb begin
      flags_raw             = '0;
      flags_raw[FLAG_VCMP]  = vcmp_i;
      flags_raw[FLAG_LIMHI] = ilim_hi_i;
      flags_raw[FLAG_LIMLO] = ilim_lo_i;
      flags_raw[FLAG_ZERO]  = izero_i;
   end

   bgs_sync #(
      .WIDTH  (FLAG_COUNT),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (flags_raw),
      .q_o   (flags_s)
   );

   assign vcmp_s   = flags_s[FLAG_VCMP];
   assign lim_hi_s = flags_s[FLAG_LIMHI];
   assign lim_lo_s = flags_s[FLAG_LIMLO];
   assign zero_s   = flags_s[FLAG_ZERO];

   bgs_decide u_decide (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_en   (run_en_i),
      .force_lo (force_lo_i),
      .pwrsave  (pwrsave_i),
      .vcmp_s   (vcmp_s),
      .lim_hi_s (lim_hi_s),
      .lim_lo_s (lim_lo_s),
      .zero_s   (zero_s),
      .want_o   (want)
   );

   bgs_deadtime #(
      .DEAD_CYCLES (DEAD_CYCLES)
   ) u_dead (
      .clk    (clk),
      .rst_n  (rst_n),
      .want_i (want),
      .hs_o   (hs_gate_o),
      .ls_o   (ls_gate_o)
   );

endmodule

// File: rtl/bgs_chk.sv
module bgs_chk #(
   parameter int unsigned DEAD_CYCLES = 4
) (
   input logic clk,
   input logic rst_n,
   input logic run_en_i,
   input logic force_lo_i,
   input logic pwrsave_i,
   input logic vcmp_s,
   input logic lim_hi_s,
   input logic zero_s,
   input logic hs_gate_o,
   input logic ls_gate_o
);

   localparam int unsigned CW = $clog2(DEAD_CYCLES + 1);
   localparam logic [CW-1:0] GAP_MAX = CW'(DEAD_CYCLES);

   logic [CW-1:0] idle_run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_run_q <= GAP_MAX;
      end else if (hs_gate_o || ls_gate_o) begin
         idle_run_q <= '0;
      end else if (idle_run_q != GAP_MAX) begin
         idle_run_q <= idle_run_q + 1'b1;
      end
   end

   // R1
   rst_idle_chk: assert property (@(posedge clk) !rst_n |-> (!hs_gate_o && !ls_gate_o));

   // R4
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_gate_o && ls_gate_o));

   // R2
   run_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en_i |=> (!hs_gate_o && !ls_gate_o));

   // R5
   hs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_gate_o) |-> (idle_run_q >= GAP_MAX));

   // R5
   ls_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_gate_o) |-> (idle_run_q >= GAP_MAX));

   // R6
   limit_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en_i && lim_hi_s) |=> !hs_gate_o);

   // R8
   zero_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en_i && !force_lo_i && pwrsave_i && zero_s && !vcmp_s) |=> !ls_gate_o);

   // R9
   force_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en_i && force_lo_i) |=> !hs_gate_o);

endmodule

bind buck_gate_seq bgs_chk #(
   .DEAD_CYCLES (DEAD_CYCLES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .run_en_i   (run_en_i),
   .force_lo_i (force_lo_i),
   .pwrsave_i  (pwrsave_i),
   .vcmp_s     (vcmp_s),
   .lim_hi_s   (lim_hi_s),
   .zero_s     (zero_s),
   .hs_gate_o  (hs_gate_o),
   .ls_gate_o  (ls_gate_o)
);

// File: tb/test_buck_gate_seq.sv
module test_buck_gate_seq;

   localparam int CLK_PERIOD = 10;
   localparam int DEAD       = 4;
   localparam int STAGES     = 2;
   localparam int RAND_CYCLES = 4000;

   logic clk = 1'b0;
   logic rst_n = 1'b1;
   logic run_en = 1'b0, force_lo = 1'b0, pwrsave = 1'b0;
   logic vcmp = 1'b0, ilim_hi = 1'b0, ilim_lo = 1'b0, izero = 1'b0;
   logic tg, bg;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   bit model_on = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   buck_gate_seq #(
      .SYNC_STAGES (STAGES),
      .DEAD_CYCLES (DEAD)
   ) i_buck_gate_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_en_i   (run_en),
      .force_lo_i (force_lo),
      .pwrsave_i  (pwrsave),
      .vcmp_i     (vcmp),
      .ilim_hi_i  (ilim_hi),
      .ilim_lo_i  (ilim_lo),
      .izero_i    (izero),
      .hs_gate_o  (tg),
      .ls_gate_o  (bg)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   // ---- reference model: sides 0 idle, 1 high, 2 low ----
   logic [3:0] m_s1, m_s2;   // {zero, lim_lo, lim_hi, vcmp}
   logic m_hold, m_idle;
   int   m_side, m_cnt;

   function automatic int exp_side(input bit run, input bit frc, input bit hs, input bit idle);
      if (!run) return 0;
      if (frc) return 2;
      if (hs) return 1;
      if (idle) return 0;
      return 2;
   endfunction

   always @(posedge clk or negedge rst_n) begin : mdl
      logic hn, hs, idn;
      int   w;
      if (!rst_n) begin
         m_s1 = '0; m_s2 = '0; m_hold = 1'b0; m_idle = 1'b0; m_side = 0; m_cnt = 0;
      end else begin
         hn = m_s2[1] | (m_hold & m_s2[2]);
         hs = m_s2[0] & ~hn;
         idn = pwrsave & ~hs & (m_s2[3] | m_idle);
         w = exp_side(run_en, force_lo, hs, idn);
         if (m_side != 0) begin
            if (w != m_side) begin m_side = 0; m_cnt = DEAD - 1; end
         end else if (m_cnt != 0) begin
            m_cnt = m_cnt - 1;
         end else begin
            m_side = w;
         end
         m_hold = run_en & hn;
         m_idle = run_en & idn;
         m_s2 = m_s1;
         m_s1 = {izero, ilim_lo, ilim_hi, vcmp};
      end
   end

   always @(negedge clk) begin
      if (model_on && rst_n) begin
         chk("R3 R6 R7 R8 R9 model high-side", tg, m_side == 1);
         chk("R2 R3 R8 R9 model low-side", bg, m_side == 2);
         chk("R4 overlap", tg & bg, 1'b0);
      end
   end

   // ---- watchdog ----
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      #1 rst_n = 1'b0;
      step(3);
      chk("R1 reset high-side", tg, 1'b0);
      chk("R1 reset low-side", bg, 1'b0);

      rst_n = 1'b1;
      run_en = 1'b1;
      model_on = 1'b1;
      step(1);
      chk("R3 low side on comparator low", bg, 1'b1);

      // R3 / R10 / R5: comparator rises
      vcmp = 1'b1;
      step(STAGES);
      chk("R10 no reaction before sync", bg, 1'b1);
      step(1);
      chk("R3 low side released", bg, 1'b0);
      step(DEAD - 1);
      chk("R5 still in dead time", tg, 1'b0);
      step(1);
      chk("R3 high side after dead time", tg, 1'b1);

      // R6 / R7: current limit
      ilim_hi = 1'b1; ilim_lo = 1'b1;
      step(STAGES + 1);
      chk("R6 high side cut by upper limit", tg, 1'b0);
      step(DEAD);
      chk("R6 low side during limit", bg, 1'b1);
      ilim_hi = 1'b0;
      step(6);
      chk("R6 hold while lower flag set", tg, 1'b0);
      chk("R7 low interval continues", bg, 1'b1);
      ilim_lo = 1'b0;
      step(STAGES + 1);
      chk("R7 low interval ends at lower limit", bg, 1'b0);
      step(DEAD);
      chk("R7 high side resumes", tg, 1'b1);

      // R8: powersave zero crossing
      vcmp = 1'b0; pwrsave = 1'b1;
      step(STAGES + 1 + DEAD);
      chk("R8 low side before crossing", bg, 1'b1);
      izero = 1'b1;
      step(STAGES);
      chk("R8 crossing not yet seen", bg, 1'b1);
      step(1);
      chk("R8 low side dropped at crossing", bg, 1'b0);
      izero = 1'b0;
      step(5);
      chk("R8 idle latched after crossing clears", bg, 1'b0);
      chk("R8 high side stays off", tg, 1'b0);
      pwrsave = 1'b0;
      step(1);
      chk("R8 low side back when powersave off", bg, 1'b1);

      // R9: force low side
      vcmp = 1'b1;
      step(STAGES + 1 + DEAD);
      chk("R9 high side before force", tg, 1'b1);
      force_lo = 1'b1;
      step(1);
      chk("R9 high side cut by force", tg, 1'b0);
      step(DEAD - 1);
      chk("R9 low side waits dead time", bg, 1'b0);
      step(1);
      chk("R9 low side forced on", bg, 1'b1);
      ilim_hi = 1'b1;
      step(5);
      chk("R9 force holds low side", bg, 1'b1);
      chk("R9 force holds high side off", tg, 1'b0);
      ilim_hi = 1'b0;

      // R2: run enable dominates force
      run_en = 1'b0;
      step(1);
      chk("R2 high side off when disabled", tg, 1'b0);
      chk("R2 low side off when disabled", bg, 1'b0);
      step(4);
      chk("R2 stays off", bg, 1'b0);
      force_lo = 1'b0;
      run_en = 1'b1;

      // random phase, compared against the model every cycle
      for (int c = 0; c < RAND_CYCLES; c++) begin
         @(negedge clk);
         if ($urandom % 6 == 0)   vcmp     = ~vcmp;
         if ($urandom % 30 == 0)  ilim_hi  = ~ilim_hi;
         if ($urandom % 15 == 0)  ilim_lo  = ~ilim_lo;
         if ($urandom % 10 == 0)  izero    = ~izero;
         if ($urandom % 50 == 0)  pwrsave  = ~pwrsave;
         if ($urandom % 150 == 0) force_lo = ~force_lo;
         if ($urandom % 100 == 0) run_en   = ~run_en;
         if (!run_en && ($urandom % 8 == 0)) run_en = 1'b1;
      end
      step(2);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule